// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-wire link to a 10-bit successive-approximation converter. It drives a chip-select line and a serial clock and samples the converter's data line. Each transfer returns the result of the conversion started by the transfer before it, most significant bit first. The converter begins sampling during a transfer and converts after the tenth falling clock edge. The controller therefore spaces transfers by a conversion wait. It keeps every chip-select level for a minimum time. When a transfer runs past ten clocks, it issues the eleventh clock before a deadline.

Software-side logic configures the framing and then pulses `start`. Two framings are available. In the toggled framing, chip select rises after every transfer and the transfer length can be set from 10 to 16 clocks. In the held framing, chip select stays low from one transfer to the next. The `cfg_slow` input picks the pace of the clocks that follow the tenth. The block does not check the zero bits that the converter sends after the tenth bit. It flags each result as slow or fast, depending on when the transfer finished relative to the conversion wait. The result of the first transfer after reset holds no real conversion, so the block drops it.

Top module: `adc_serial_reader`

## Requirements
- R1: Reset drives `adc_cs_n` high, `adc_sclk` low and `result_valid` low, and leaves `ready` high.
- R2: The first transfer after reset produces no `result_valid` pulse.
- R3: The block samples `adc_sdo` at each of the first ten rising edges of `adc_sclk`. The first sample is bit 9 of `result` and the tenth is bit 0.
- R4: Levels on `adc_sdo` after the tenth falling edge of `adc_sclk` have no effect on `result`.
- R5: With `cfg_hold_low`=0, `adc_cs_n` falls when a transfer is accepted and rises after it. The transfer has `cfg_len` clocks, where a value below 10 counts as 10 and a value above 16 counts as 16.
- R6: With `cfg_hold_low`=1, `adc_cs_n` stays low between transfers and `cfg_len` is ignored. A transfer has 10 clocks when `cfg_slow`=0 and 16 clocks when `cfg_slow`=1.
- R7: Each level of `adc_cs_n` lasts at least `CS_MIN_CYC` cycles.
- R8: The first rising edge of `adc_sclk` in a transfer comes at least `CONV_WAIT_CYC` cycles after the tenth falling edge of the previous transfer.
- R9: `adc_sclk` high and low phases last `HALF_CYC` cycles. With `cfg_slow`=1, each phase after the tenth falling edge lasts `TAIL_HALF_CYC` cycles, but never more than `ELEVENTH_LIMIT_CYC`. As a result, the eleventh rising edge follows the tenth falling edge by no more than `ELEVENTH_LIMIT_CYC` cycles.
- R10: `result_slow` is 1 when the last falling edge of the transfer came at least `CONV_WAIT_CYC` cycles after the tenth falling edge, and 0 otherwise. A 10-clock transfer always gives 0.
- R11: A `start` pulse while `ready` is low is ignored: it adds no clocks and no result.
- R12: `result_valid` is a single-cycle pulse, once per transfer after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transfer when `ready` is high |
| cfg_hold_low | input | 1 | 1 = chip select held low between transfers |
| cfg_slow | input | 1 | 1 = slow pacing of clocks after the tenth |
| cfg_len | input | LEN_W | Clock count for toggled framing, 10 to 16 |
| ready | output | 1 | A `start` would be accepted this cycle |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial I/O clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| result | output | DATA_W | Last ten-bit result |
| result_valid | output | 1 | One-cycle pulse when `result` is new |
| result_slow | output | 1 | The transfer that gave `result` ended after the conversion wait |

## Verification
A wrong clock counter shows at the pins within one transfer. The number of `adc_sclk` pulses between chip-select edges is off, or `result` is shifted by a bit position. A timer that restarts in the wrong cycle moves the first rising edge of the next transfer closer than the conversion wait, or lets chip select change early. Both appear within a few hundred cycles. A stale first-result flag shows up as a `result_valid` pulse on the very first transfer. A bad phase selector shows up as a wrong gap between the tenth falling edge and the eleventh rising edge.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;
  typedef enum logic [2:0] {
    RD_IDLE,
    RD_SETUP,
    RD_HIGH,
    RD_LOW,
    RD_FINISH,
    RD_CSUP
  } rd_state_e;
endpackage

// File: rtl/adcrd_sat_timer.sv
`timescale 1ns/1ps
// Counts cycles since the last restart and saturates at LIMIT.
// It comes out of reset already saturated, so nothing waits after reset.
module adcrd_sat_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic reached
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= LIM;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = (cnt_q == LIM);
endmodule

// File: rtl/adcrd_half_cnt.sv
`timescale 1ns/1ps
// Down counter that times one phase of the serial clock.
module adcrd_half_cnt #(
  parameter int unsigned MAXV = 40,
  localparam int unsigned CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adcrd_capture.sv
`timescale 1ns/1ps
// Shift register that collects the result, most significant bit first.
module adcrd_capture #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr)    sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[W-2:0], bit_in};
  end

  assign word = sh_q;
endmodule

// File: rtl/adc_serial_reader.sv
`timescale 1ns/1ps
module adc_serial_reader
  import adcrd_pkg::*;
#(
  parameter int unsigned DATA_W             = 10,
  parameter int unsigned MAX_CLKS           = 16,
  parameter int unsigned HALF_CYC           = 4,
  parameter int unsigned TAIL_HALF_CYC      = 40,
  parameter int unsigned CONV_WAIT_CYC      = 200,
  parameter int unsigned ELEVENTH_LIMIT_CYC = 95,
  parameter int unsigned CS_MIN_CYC         = 15,
  localparam int unsigned LEN_W = $clog2(MAX_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_hold_low,
  input  logic              cfg_slow,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              ready,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdo,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              result_slow
);
  // The tail phase is capped so that the eleventh rising edge always meets its deadline.
  localparam int unsigned TAIL_EFF = (TAIL_HALF_CYC <= ELEVENTH_LIMIT_CYC) ?
                                     TAIL_HALF_CYC : ELEVENTH_LIMIT_CYC;
  localparam int unsigned HALF_EFF = (HALF_CYC <= ELEVENTH_LIMIT_CYC) ?
                                     HALF_CYC : ELEVENTH_LIMIT_CYC;
  localparam int unsigned HMAX = (TAIL_EFF > HALF_EFF) ? TAIL_EFF : HALF_EFF;
  localparam int unsigned HW   = $clog2(HMAX + 1);
  localparam logic [LEN_W-1:0] FRAME_L = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_CLKS);
  localparam logic [HW-1:0]    HALF_M1 = HW'(HALF_EFF - 1);
  localparam logic [HW-1:0]    TAIL_M1 = HW'(TAIL_EFF - 1);

  rd_state_e          state_q;
  logic               cs_n_q, sclk_q;
  logic [LEN_W-1:0]   clk_cnt_q, len_q;
  logic               hold_q, slow_q, seen_q;
  logic               valid_q, rslow_q;
  logic [DATA_W-1:0]  res_q;

  logic               conv_ok, cs_ok, half_exp;
  logic               accept, fall_now, rise_now;
  logic               cs_restart, conv_restart, half_load, cap_en;
  logic [HW-1:0]      half_val;
  logic [LEN_W-1:0]   cnt_next, eff_len;
  logic [DATA_W-1:0]  cap_word;

  function automatic logic [HW-1:0] phase_m1(input logic slow, input logic [LEN_W-1:0] n);
    return (slow && (n >= FRAME_L)) ? TAIL_M1 : HALF_M1;
  endfunction

  // Transfer length for the requested framing.
  always_comb begin
    if (cfg_hold_low)           eff_len = cfg_slow ? MAX_L : FRAME_L;
    else if (cfg_len < FRAME_L) eff_len = FRAME_L;
    else if (cfg_len > MAX_L)   eff_len = MAX_L;
    else                        eff_len = cfg_len;
  end

  assign ready    = (state_q == RD_IDLE) && conv_ok && cs_ok;
  assign accept   = ready && start;
  assign fall_now = (state_q == RD_HIGH) && half_exp;
  assign rise_now = ((state_q == RD_SETUP) && cs_ok) ||
                    ((state_q == RD_LOW) && half_exp);
  assign cnt_next = clk_cnt_q + 1'b1;

  always_comb begin
    cs_restart   = (accept && cs_n_q) || ((state_q == RD_CSUP) && cs_ok);
    conv_restart = fall_now && (cnt_next == FRAME_L);
    half_load    = rise_now || (fall_now && (cnt_next != len_q));
    half_val     = rise_now ? phase_m1(slow_q, clk_cnt_q) : phase_m1(slow_q, cnt_next);
    cap_en       = rise_now && (clk_cnt_q < FRAME_L);
  end

  adcrd_sat_timer #(.LIMIT(CONV_WAIT_CYC)) u_conv (
    .clk(clk), .rst(rst), .restart(conv_restart), .reached(conv_ok)
  );

  adcrd_sat_timer #(.LIMIT(CS_MIN_CYC)) u_cshold (
    .clk(clk), .rst(rst), .restart(cs_restart), .reached(cs_ok)
  );

  adcrd_half_cnt #(.MAXV(HMAX)) u_phase (
    .clk(clk), .rst(rst), .load(half_load), .load_val(half_val), .expired(half_exp)
  );

  adcrd_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .clr(accept), .shift_en(cap_en), .bit_in(adc_sdo), .word(cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RD_IDLE;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
      clk_cnt_q <= '0;
      len_q     <= FRAME_L;
      hold_q    <= 1'b0;
      slow_q    <= 1'b0;
      seen_q    <= 1'b0;
      valid_q   <= 1'b0;
      rslow_q   <= 1'b0;
      res_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        RD_IDLE: if (accept) begin
          hold_q    <= cfg_hold_low;
          slow_q    <= cfg_slow;
          len_q     <= eff_len;
          clk_cnt_q <= '0;
          cs_n_q    <= 1'b0;
          state_q   <= RD_SETUP;
        end
        RD_SETUP: if (cs_ok) begin
          sclk_q  <= 1'b1;
          state_q <= RD_HIGH;
        end
        RD_HIGH: if (half_exp) begin
          sclk_q    <= 1'b0;
          clk_cnt_q <= cnt_next;
          state_q   <= (cnt_next == len_q) ? RD_FINISH : RD_LOW;
        end
        RD_LOW: if (half_exp) begin
          sclk_q  <= 1'b1;
          state_q <= RD_HIGH;
        end
        RD_FINISH: begin
          valid_q <= seen_q;
          seen_q  <= 1'b1;
          res_q   <= cap_word;
          rslow_q <= conv_ok;
          state_q <= hold_q ? RD_IDLE : RD_CSUP;
        end
        RD_CSUP: if (cs_ok) begin
          cs_n_q  <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign adc_cs_n     = cs_n_q;
  assign adc_sclk     = sclk_q;
  assign result       = res_q;
  assign result_valid = valid_q;
  assign result_slow  = rslow_q;
endmodule

// File: rtl/adcrd_checker.sv
`timescale 1ns/1ps
module adcrd_checker #(
  parameter int unsigned DATA_W             = 10,
  parameter int unsigned MAX_CLKS           = 16,
  parameter int unsigned CNT_W              = 5,
  parameter int unsigned CONV_WAIT_CYC      = 200,
  parameter int unsigned ELEVENTH_LIMIT_CYC = 95,
  parameter int unsigned CS_MIN_CYC         = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sclk,
  input logic             valid,
  input logic             hold_mode,
  input logic [CNT_W-1:0] fall_cnt
);
  localparam int unsigned CAP = (CONV_WAIT_CYC > ELEVENTH_LIMIT_CYC + 1) ?
                                CONV_WAIT_CYC : ELEVENTH_LIMIT_CYC + 1;
  localparam int unsigned SW  = $clog2(CAP + 1);
  localparam int unsigned RW  = $clog2(CS_MIN_CYC + 1);
  localparam logic [SW-1:0]    CAP_S  = SW'(CAP);
  localparam logic [SW-1:0]    CONV_S = SW'(CONV_WAIT_CYC);
  localparam logic [SW-1:0]    ELEV_S = SW'(ELEVENTH_LIMIT_CYC);
  localparam logic [RW-1:0]    CSM_R  = RW'(CS_MIN_CYC);
  localparam logic [CNT_W-1:0] TEN_C  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_CLKS);

  logic          sclk_d, cs_d;
  logic [SW-1:0] since10;
  logic [RW-1:0] cs_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      since10 <= CAP_S;
      cs_run  <= CSM_R;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (sclk_d && !sclk && (fall_cnt == TEN_C)) since10 <= SW'(1);
      else if (since10 != CAP_S)                   since10 <= since10 + 1'b1;
      if (cs_d != cs_n)           cs_run <= RW'(1);
      else if (cs_run != CSM_R)   cs_run <= cs_run + 1'b1;
    end
  end

  // R8: a new transfer begins only after the conversion wait
  p_conv_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && (fall_cnt == '0)) |-> (since10 >= CONV_S));

  // R9: eleventh rising edge meets its deadline
  p_eleventh_deadline_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && (fall_cnt == TEN_C)) |-> (since10 <= ELEV_S));

  // R7: chip select keeps each level for the minimum time
  p_cs_min_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_d != cs_n) |-> (cs_run >= CSM_R));

  // R6: chip select never rises in held framing
  p_cs_held_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !hold_mode);

  // R12: valid is a single-cycle pulse
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R5: never more than the maximum number of clocks in a transfer
  p_max_clocks_r5: assert property (@(posedge clk) disable iff (rst)
    fall_cnt <= MAX_C);
endmodule

bind adc_serial_reader adcrd_checker #(
  .DATA_W(DATA_W),
  .MAX_CLKS(MAX_CLKS),
  .CNT_W(LEN_W),
  .CONV_WAIT_CYC(CONV_WAIT_CYC),
  .ELEVENTH_LIMIT_CYC(ELEVENTH_LIMIT_CYC),
  .CS_MIN_CYC(CS_MIN_CYC)
) u_chk (
  .clk(clk),
  .rst(rst),
  .cs_n(adc_cs_n),
  .sclk(adc_sclk),
  .valid(result_valid),
  .hold_mode(hold_q),
  .fall_cnt(clk_cnt_q)
);

// File: tb/sim_adc_serial_reader.sv
`timescale 1ns/1ps
module sim_adc_serial_reader;
  localparam int HALF  = 4;
  localparam int TAIL  = 40;
  localparam int CONV  = 200;
  localparam int ELEV  = 95;
  localparam int CSMIN = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cfg_hold_low = 1'b0;
  logic       cfg_slow = 1'b0;
  logic [4:0] cfg_len = 5'd10;
  logic       ready, adc_cs_n, adc_sclk;
  logic       adc_sdo = 1'b1;
  logic [9:0] result;
  logic       result_valid, result_slow;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adc_serial_reader #(
    .DATA_W(10), .MAX_CLKS(16), .HALF_CYC(HALF), .TAIL_HALF_CYC(TAIL),
    .CONV_WAIT_CYC(CONV), .ELEVENTH_LIMIT_CYC(ELEV), .CS_MIN_CYC(CSMIN)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_hold_low(cfg_hold_low),
    .cfg_slow(cfg_slow), .cfg_len(cfg_len), .ready(ready), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_sdo(adc_sdo), .result(result),
    .result_valid(result_valid), .result_slow(result_slow)
  );

  function automatic logic [9:0] wordf(input int k);
    return 10'((k * 389 + 613) % 1024);
  endfunction

  // Converter model plus monitor; runs on the falling system-clock edge.
  int cyc = 0, mcnt = 0, widx = 0, model_len = 10;
  logic model_hold = 1'b0;
  logic sclk_p = 1'b0, cs_p = 1'b1, valid_p = 1'b0;
  logic [9:0] sh = '1, cur_word = '0, act_word = '0, last_res = '0, last_exp = '0;
  logic last_slow = 1'b0;
  int rises = 0, t10 = -100000, gap_last = 0, r11_last = 0;
  int hi_start = 0, first_hi = 0, vcount = 0, vdouble = 0;
  int cs_fall_cyc = 0, cs_low_len = 0, cs_rises = 0;

  always @(negedge clk) begin
    cyc++;
    if (cs_p && !adc_cs_n) begin
      cur_word = wordf(widx); widx++; sh = cur_word; mcnt = 0; cs_fall_cyc = cyc;
    end
    if (!cs_p && adc_cs_n) begin
      cs_low_len = cyc - cs_fall_cyc; cs_rises++;
    end
    if (!sclk_p && adc_sclk) begin
      rises++; hi_start = cyc;
      if (mcnt == 0) begin act_word = cur_word; gap_last = cyc - t10; end
      if (mcnt == 10) r11_last = cyc - t10;
    end
    if (sclk_p && !adc_sclk) begin
      if (mcnt == 0) first_hi = cyc - hi_start;
      mcnt++;
      if (mcnt == 10) begin t10 = cyc; sh = '1; end  // junk ones after the tenth bit
      else sh = {sh[8:0], 1'b1};
      if (model_hold && mcnt == model_len) begin
        cur_word = wordf(widx); widx++; sh = cur_word; mcnt = 0;
      end
    end
    adc_sdo = sh[9];
    if (result_valid) begin
      vcount++; last_res = result; last_exp = act_word; last_slow = result_slow;
      if (valid_p) vdouble++;
    end
    valid_p = result_valid;
    sclk_p  = adc_sclk;
    cs_p    = adc_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(1'b0, "R11", "ready timeout", 0, 1);
  endtask

  int r0, v0;
  task automatic run_xfer(input logic hold, input logic slow, input int len_cfg, input int len_eff);
    wait_ready();
    cfg_hold_low = hold; cfg_slow = slow; cfg_len = 5'(len_cfg);
    model_hold = hold; model_len = len_eff;
    r0 = rises; v0 = vcount;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    wait_ready();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(adc_cs_n == 1'b1, "R1", "cs_n after reset", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1", "sclk after reset", int'(adc_sclk), 0);
    chk(result_valid == 1'b0, "R1", "valid after reset", int'(result_valid), 0);
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
  endtask

  task automatic t_first_discard();
    run_xfer(1'b0, 1'b0, 10, 10);
    chk(vcount - v0 == 0, "R2", "valid on first transfer", vcount - v0, 0);
    chk(rises - r0 == 10, "R5", "clocks len 10", rises - r0, 10);
    chk(first_hi == HALF, "R9", "high phase length", first_hi, HALF);
    chk(adc_cs_n == 1'b1, "R5", "cs_n after toggled transfer", int'(adc_cs_n), 1);
  endtask

  task automatic t_toggle10();
    run_xfer(1'b0, 1'b0, 10, 10);
    chk(vcount - v0 == 1, "R3", "valid count", vcount - v0, 1);
    chk(last_res == last_exp, "R3", "result len 10", int'(last_res), int'(last_exp));
    chk(last_slow == 1'b0, "R10", "slow flag len 10", int'(last_slow), 0);
    chk(cs_low_len >= CSMIN, "R7", "cs low length", cs_low_len, CSMIN);
    chk(gap_last >= CONV, "R8", "gap after tenth fall", gap_last, CONV);
    chk(vdouble == 0, "R12", "valid wider than one cycle", vdouble, 0);
  endtask

  task automatic t_toggle16_fast();
    run_xfer(1'b0, 1'b0, 16, 16);
    chk(rises - r0 == 16, "R5", "clocks len 16", rises - r0, 16);
    chk(last_res == last_exp, "R4", "result with junk tail", int'(last_res), int'(last_exp));
    chk(last_slow == 1'b0, "R10", "slow flag fast 16", int'(last_slow), 0);
  endtask

  task automatic t_toggle13_slow();
    run_xfer(1'b0, 1'b1, 13, 13);
    chk(rises - r0 == 13, "R5", "clocks len 13", rises - r0, 13);
    chk(r11_last == TAIL, "R9", "eleventh rise delay", r11_last, TAIL);
    chk(r11_last <= ELEV, "R9", "eleventh rise deadline", r11_last, ELEV);
    chk(last_slow == 1'b1, "R10", "slow flag slow 13", int'(last_slow), 1);
    chk(last_res == last_exp, "R3", "result slow 13", int'(last_res), int'(last_exp));
  endtask

  task automatic t_clamp();
    run_xfer(1'b0, 1'b0, 20, 16);
    chk(rises - r0 == 16, "R5", "len 20 clamped", rises - r0, 16);
    run_xfer(1'b0, 1'b0, 5, 10);
    chk(rises - r0 == 10, "R5", "len 5 clamped", rises - r0, 10);
    chk(last_res == last_exp, "R3", "result after clamp", int'(last_res), int'(last_exp));
  endtask

  task automatic t_busy_start();
    wait_ready();
    cfg_hold_low = 1'b0; cfg_slow = 1'b0; cfg_len = 5'd12;
    model_hold = 1'b0; model_len = 12;
    r0 = rises; v0 = vcount;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    chk(ready == 1'b0, "R11", "ready during transfer", int'(ready), 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    wait_ready();
    repeat (400) @(negedge clk);
    chk(rises - r0 == 12, "R11", "clocks with extra start", rises - r0, 12);
    chk(vcount - v0 == 1, "R11", "results with extra start", vcount - v0, 1);
  endtask

  task automatic t_hold_fast();
    int csr;
    run_xfer(1'b1, 1'b0, 13, 10);
    csr = cs_rises;
    chk(rises - r0 == 10, "R6", "held fast clocks", rises - r0, 10);
    run_xfer(1'b1, 1'b0, 13, 10);
    chk(rises - r0 == 10, "R6", "held fast clocks again", rises - r0, 10);
    chk(cs_rises == csr, "R6", "cs rises in held framing", cs_rises - csr, 0);
    chk(adc_cs_n == 1'b0, "R6", "cs_n stays low", int'(adc_cs_n), 0);
    chk(last_res == last_exp, "R6", "held fast result", int'(last_res), int'(last_exp));
    chk(gap_last >= CONV, "R8", "held gap after tenth fall", gap_last, CONV);
  endtask

  task automatic t_hold_slow();
    run_xfer(1'b1, 1'b1, 10, 16);
    chk(rises - r0 == 16, "R6", "held slow clocks", rises - r0, 16);
    chk(last_slow == 1'b1, "R10", "held slow flag", int'(last_slow), 1);
    chk(last_res == last_exp, "R4", "held slow result", int'(last_res), int'(last_exp));
    chk(adc_cs_n == 1'b0, "R6", "cs_n low after slow", int'(adc_cs_n), 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_discard();
    t_toggle10();
    t_toggle16_fast();
    t_toggle13_slow();
    t_clamp();
    t_busy_start();
    t_hold_fast();
    t_hold_slow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1-run actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule